// File: doc/BRIEF.md
# Three-Beat Tagged Word Link

This block moves a wide trigger pattern from one logic level to the next over a 32-bit parallel port. It does this by running the port at three times the frame rate. Each frame period holds three transfer beats. The transmitter cuts an 87-bit payload into three 29-bit pieces. It sends each piece in one beat and puts a 3-bit sequence marker in the upper bits of that beat. The receiver reads the markers and rebuilds the payload. It reports any beat that arrives out of turn.

Both halves run on the fast beat clock. The transmitter presents a ready signal that is high one cycle in three while frames follow each other. When no payload is offered, it sends all-zero idle beats. The receiver raises a one-cycle frame strobe when a complete frame arrives. It raises a one-cycle error strobe for each beat that breaks the expected order. After an error it picks up again at the next first beat. In the top module the two halves are independent, so the link input can come from the local transmitter or from a remote one.

Top module: `tri_beat_link`

## Requirements
- R1: A payload accepted at a clock edge appears on `link_out` over the next three cycles. The beat word is tag in bits 31..29 and piece in bits 28..0. The three beats, in order, are tag 3'b001 with payload[28:0], tag 3'b010 with payload[57:29], and tag 3'b100 with payload[86:58].
- R2: When no beat is due, `link_out` is all zeros (tag 3'b000 means idle).
- R3: `tx_ready` is high while the transmitter is idle and during the cycle its third beat is on `link_out`. It is low during the first and second beats. With `tx_valid` held high, payloads are therefore taken exactly every three cycles, with no idle beat between frames.
- R4: After `link_in` carries tags 3'b001, 3'b010 and 3'b100 on three consecutive edges, `rx_frame_valid` is high for exactly one cycle, the cycle after the edge that samples the third beat. In that same cycle `rx_payload` holds {piece3, piece2, piece1}. A transmitter looped back to the receiver produces every frame this way and no error.
- R5: `rx_payload` changes only when a frame completes. A sequence error leaves it unchanged.
- R6: If a partial frame is being collected and the next beat carries the wrong tag (including idle), the partial frame is discarded. `rx_seq_error` pulses for one cycle and `rx_frame_valid` stays low.
- R7: While waiting for a first beat, every beat tagged 3'b010 or 3'b100 pulses `rx_seq_error`.
- R8: A beat tagged 3'b001 that arrives in the middle of a frame pulses `rx_seq_error`. It then starts a new frame as its first beat.
- R9: A beat whose tag has more than one bit set pulses `rx_seq_error`.
- R10: Idle beats while waiting for a first beat cause no error and no frame.
- R11: After reset, `link_out`, `rx_payload`, `rx_frame_valid` and `rx_seq_error` are zero and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, three times the frame rate |
| rst | input | 1 | Synchronous active-high reset |
| tx_payload | input | 87 | Payload offered to the transmitter |
| tx_valid | input | 1 | Payload offer |
| tx_ready | output | 1 | Transmitter takes the payload at this edge if `tx_valid` is high |
| link_out | output | 32 | Registered beat word driven onto the link |
| link_in | input | 32 | Beat word received from the link |
| rx_payload | output | 87 | Last complete frame |
| rx_frame_valid | output | 1 | One-cycle strobe: a frame completed |
| rx_seq_error | output | 1 | One-cycle strobe: a beat broke the sequence |

## Verification
The properties place no constraint on `tx_payload` or on `link_in`. The receiver-side checks hold for any beat stream, because they tie the strobes only to the tag sampled one edge earlier. The checks expect reset to be held for at least one edge before traffic starts. The stimulus alternates between two modes. In one, the link input is looped back from the transmitter so that whole frames are exercised. In the other, hand-built beat words are injected. The switch between modes happens only while the transmitter is idle and the receiver is waiting for a first beat, so no partial frame crosses the switch.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  localparam int LINK_BEATS   = 3;
  localparam int LINK_PIECE_W = 29;
endpackage

// File: rtl/tbl_beat_tx.sv
module tbl_beat_tx #(
  parameter int BEATS   = tbl_pkg::LINK_BEATS,
  parameter int PIECE_W = tbl_pkg::LINK_PIECE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [BEATS*PIECE_W-1:0]   pay_i,
  input  logic                       valid_i,
  output logic                       ready_o,
  output logic [BEATS+PIECE_W-1:0]   word_o
);
  localparam int TAG_W  = BEATS;
  localparam int WORD_W = TAG_W + PIECE_W;
  localparam int IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [PIECE_W-1:0] slice_in [BEATS];
  logic [PIECE_W-1:0] hold [1:BEATS-1];
  logic               busy;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   nxt;
  logic               at_last;
  logic               accept;

  genvar g;
  generate
    for (g = 0; g < BEATS; g++) begin : g_slice
      assign slice_in[g] = pay_i[g*PIECE_W +: PIECE_W];
    end
  endgenerate

  assign at_last = (idx == IDX_W'(BEATS-1));
  assign nxt     = idx + IDX_W'(1);
  assign ready_o = !busy || at_last;
  assign accept  = valid_i && ready_o;

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int b = 1; b < BEATS; b++) hold[b] <= slice_in[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx    <= '0;
      word_o <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      idx    <= '0;
      word_o <= {TAG_W'(1), slice_in[0]};
    end else if (busy && !at_last) begin
      idx    <= nxt;
      word_o <= {TAG_W'(1) << nxt, hold[nxt]};
    end else begin
      busy   <= 1'b0;
      idx    <= '0;
      word_o <= WORD_W'(0);
    end
  end
endmodule

// File: rtl/tbl_beat_rx.sv
module tbl_beat_rx #(
  parameter int BEATS   = tbl_pkg::LINK_BEATS,
  parameter int PIECE_W = tbl_pkg::LINK_PIECE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [BEATS+PIECE_W-1:0]   word_i,
  output logic [BEATS*PIECE_W-1:0]   pay_o,
  output logic                       frame_o,
  output logic                       err_o
);
  localparam int TAG_W  = BEATS;
  localparam int WORD_W = TAG_W + PIECE_W;
  localparam int PAY_W  = BEATS * PIECE_W;
  localparam int IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [TAG_W-1:0]   tag;
  logic [PIECE_W-1:0] piece;
  logic [IDX_W-1:0]   expect_q;
  logic [IDX_W-1:0]   expect_d;
  logic [IDX_W-1:0]   slot;
  logic [TAG_W-1:0]   want;
  logic               take;
  logic               done;
  logic               bad;
  logic [PIECE_W-1:0] parts [BEATS-1];
  logic [PAY_W-1:0]   full;

  assign tag   = word_i[WORD_W-1 -: TAG_W];
  assign piece = word_i[PIECE_W-1:0];
  assign want  = TAG_W'(1) << expect_q;

  always_comb begin
    take     = 1'b0;
    done     = 1'b0;
    bad      = 1'b0;
    slot     = expect_q;
    expect_d = expect_q;
    if (tag == want) begin
      take = 1'b1;
      if (expect_q == IDX_W'(BEATS-1)) begin
        done     = 1'b1;
        expect_d = '0;
      end else begin
        expect_d = expect_q + IDX_W'(1);
      end
    end else if (tag == '0 && expect_q == '0) begin
      expect_d = '0;
    end else begin
      bad = 1'b1;
      if (tag == TAG_W'(1)) begin
        take     = 1'b1;
        slot     = '0;
        expect_d = IDX_W'(1);
      end else begin
        expect_d = '0;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < BEATS-1; g++) begin : g_full
      assign full[g*PIECE_W +: PIECE_W] = parts[g];
    end
  endgenerate
  assign full[PAY_W-1 -: PIECE_W] = piece;

  always_ff @(posedge clk) begin
    for (int b = 0; b < BEATS-1; b++) begin
      if (take && slot == IDX_W'(b)) parts[b] <= piece;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_q <= '0;
      frame_o  <= 1'b0;
      err_o    <= 1'b0;
      pay_o    <= '0;
    end else begin
      expect_q <= expect_d;
      frame_o  <= done;
      err_o    <= bad;
      if (done) pay_o <= full;
    end
  end
endmodule

// File: rtl/tri_beat_link.sv
module tri_beat_link #(
  parameter int BEATS   = tbl_pkg::LINK_BEATS,
  parameter int PIECE_W = tbl_pkg::LINK_PIECE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [BEATS*PIECE_W-1:0]   tx_payload,
  input  logic                       tx_valid,
  output logic                       tx_ready,
  output logic [BEATS+PIECE_W-1:0]   link_out,
  input  logic [BEATS+PIECE_W-1:0]   link_in,
  output logic [BEATS*PIECE_W-1:0]   rx_payload,
  output logic                       rx_frame_valid,
  output logic                       rx_seq_error
);
  tbl_beat_tx #(.BEATS(BEATS), .PIECE_W(PIECE_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .pay_i   (tx_payload),
    .valid_i (tx_valid),
    .ready_o (tx_ready),
    .word_o  (link_out)
  );

  tbl_beat_rx #(.BEATS(BEATS), .PIECE_W(PIECE_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .word_i  (link_in),
    .pay_o   (rx_payload),
    .frame_o (rx_frame_valid),
    .err_o   (rx_seq_error)
  );
endmodule

// File: rtl/tri_beat_link_chk.sv
module tri_beat_link_chk #(
  parameter int BEATS   = tbl_pkg::LINK_BEATS,
  parameter int PIECE_W = tbl_pkg::LINK_PIECE_W
) (
  input logic                       clk,
  input logic                       rst,
  input logic [BEATS*PIECE_W-1:0]   tx_payload,
  input logic                       tx_valid,
  input logic                       tx_ready,
  input logic [BEATS+PIECE_W-1:0]   link_out,
  input logic [BEATS+PIECE_W-1:0]   link_in,
  input logic [BEATS*PIECE_W-1:0]   rx_payload,
  input logic                       rx_frame_valid,
  input logic                       rx_seq_error
);
  localparam int TAG_W  = BEATS;
  localparam int WORD_W = TAG_W + PIECE_W;

  logic [TAG_W-1:0] out_tag;
  logic [TAG_W-1:0] in_tag;
  assign out_tag = link_out[WORD_W-1 -: TAG_W];
  assign in_tag  = link_in[WORD_W-1 -: TAG_W];

  a_r1_first_beat: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> (link_out == {TAG_W'(1), $past(tx_payload[PIECE_W-1:0])}));

  a_r1_beat_order: assert property (@(posedge clk) disable iff (rst)
    (out_tag == TAG_W'(1)) |=> (out_tag == TAG_W'(2)));

  a_r2_tag_shape: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_tag));

  a_r3_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_frame_valid |=> !rx_frame_valid);

  a_r4_after_last_beat: assert property (@(posedge clk) disable iff (rst)
    rx_frame_valid |-> ($past(in_tag) == TAG_W'(1) << (BEATS-1)));

  a_r5_payload_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_frame_valid |-> $stable(rx_payload));

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rx_frame_valid && rx_seq_error));

  a_r9_bad_encoding: assert property (@(posedge clk) disable iff (rst)
    !$onehot0(in_tag) |=> rx_seq_error);
endmodule

bind tri_beat_link tri_beat_link_chk #(.BEATS(BEATS), .PIECE_W(PIECE_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .tx_payload     (tx_payload),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .link_out       (link_out),
  .link_in        (link_in),
  .rx_payload     (rx_payload),
  .rx_frame_valid (rx_frame_valid),
  .rx_seq_error   (rx_seq_error)
);

// File: tb/test_tri_beat_link.sv
module test_tri_beat_link;
  localparam int PW = 29;
  localparam int PAY = 87;
  localparam int WW = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [PAY-1:0] tx_payload = '0;
  logic           tx_valid = 1'b0;
  logic           tx_ready;
  logic [WW-1:0]  link_out;
  logic [WW-1:0]  link_in;
  logic [PAY-1:0] rx_payload;
  logic           rx_frame_valid;
  logic           rx_seq_error;
  logic           inj_en = 1'b0;
  logic [WW-1:0]  inj_word = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [PAY-1:0] exp_pay [0:511];
  int             exp_cyc [0:511];
  int wr = 0;
  int rd = 0;
  int last_acc = 0;

  assign link_in = inj_en ? inj_word : link_out;

  tri_beat_link i_tri_beat_link (
    .clk(clk), .rst(rst), .tx_payload(tx_payload), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .link_out(link_out), .link_in(link_in),
    .rx_payload(rx_payload), .rx_frame_valid(rx_frame_valid),
    .rx_seq_error(rx_seq_error)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [PAY-1:0] act, input logic [PAY-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [PAY-1:0] pat(input int i);
    pat = {29'(i * 7919 + 17), 29'(i * 104729) ^ 29'h0AAAAAAA, 29'(~i)};
  endfunction

  function automatic logic [WW-1:0] beat_word(input logic [PAY-1:0] p, input int k);
    beat_word = {3'(1 << k), p[k*PW +: PW]};
  endfunction

  // loopback scoreboard
  always @(negedge clk) begin
    if (!rst && !inj_en) begin
      if (rx_seq_error) check(1'b0, "R4 no error in loopback", 87'd1, 87'd0);
      if (rx_frame_valid) begin
        check(rx_payload == exp_pay[rd], "R4 loopback payload", rx_payload, exp_pay[rd]);
        check(cyc == exp_cyc[rd], "R4 frame latency", PAY'(cyc), PAY'(exp_cyc[rd]));
        rd++;
      end
    end
  end

  // offer one payload; returns just after the accepting edge
  task automatic send(input logic [PAY-1:0] p, input bit b2b);
    @(negedge clk);
    tx_payload = p;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    if (b2b) check(cyc + 1 - last_acc == 3, "R3 back-to-back interval", PAY'(cyc + 1 - last_acc), 87'd3);
    last_acc = cyc + 1;
    exp_pay[wr] = p;
    exp_cyc[wr] = cyc + 4;
    wr++;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic send_watch(input logic [PAY-1:0] p);
    send(p, 1'b0);
    @(negedge clk);
    tx_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(link_out == beat_word(p, k), "R1 beat content", PAY'(link_out), PAY'(beat_word(p, k)));
      check(tx_ready == (k == 2), "R3 ready during beats", PAY'(tx_ready), PAY'(k == 2));
      @(negedge clk);
    end
    check(link_out == '0, "R2 idle beat", PAY'(link_out), 87'd0);
    check(tx_ready == 1'b1, "R3 ready when idle", PAY'(tx_ready), 87'd1);
    @(posedge clk);
  endtask

  // injected beat; returns at the negedge after the sampling edge
  task automatic beat(input logic [2:0] tg, input logic [PW-1:0] pc);
    inj_word = {tg, pc};
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PAY-1:0] held;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(link_out == '0, "R11 link_out reset", PAY'(link_out), 87'd0);
    check(rx_payload == '0, "R11 rx_payload reset", rx_payload, 87'd0);
    check(!rx_frame_valid && !rx_seq_error, "R11 strobes reset", PAY'({rx_frame_valid, rx_seq_error}), 87'd0);
    check(tx_ready, "R11 ready after reset", PAY'(tx_ready), 87'd1);
    @(posedge clk);

    send_watch({29'h1ABCDEF0, 29'h02468ACE, 29'h13579BDF});
    send_watch({PAY{1'b1}});
    send_watch(87'd1);
    idle(4);

    for (int i = 0; i < PAY; i++) send(PAY'(1) << i, i > 0);
    idle(6);
    for (int i = 0; i < PAY; i++) send(~(PAY'(1) << i), i > 0);
    idle(6);
    for (int i = 0; i < 64; i++) begin
      send(pat(i), 1'b0);
      idle(i % 4);
    end
    idle(8);

    @(negedge clk);
    inj_en = 1'b1;
    // R4 complete injected frame
    beat(3'b001, 29'h0000AAAA);
    beat(3'b010, 29'h0000BBBB);
    beat(3'b100, 29'h0000CCCC);
    check(rx_frame_valid, "R4 injected frame strobe", PAY'(rx_frame_valid), 87'd1);
    check(rx_payload == {29'h0000CCCC, 29'h0000BBBB, 29'h0000AAAA}, "R4 injected payload",
          rx_payload, {29'h0000CCCC, 29'h0000BBBB, 29'h0000AAAA});
    held = rx_payload;
    beat(3'b000, '0);
    check(!rx_frame_valid, "R4 strobe one cycle", PAY'(rx_frame_valid), 87'd0);
    // R6 skipped beat
    beat(3'b001, 29'h1);
    check(!rx_seq_error, "R6 first beat fine", PAY'(rx_seq_error), 87'd0);
    beat(3'b100, 29'h2);
    check(rx_seq_error && !rx_frame_valid, "R6 skipped beat error", PAY'({rx_seq_error, rx_frame_valid}), 87'b10);
    beat(3'b000, '0);
    check(!rx_seq_error, "R6 error one cycle", PAY'(rx_seq_error), 87'd0);
    check(rx_payload == held, "R5 payload kept on error", rx_payload, held);
    // R6 idle in mid-frame
    beat(3'b001, 29'h3);
    beat(3'b010, 29'h4);
    beat(3'b000, '0);
    check(rx_seq_error && !rx_frame_valid, "R6 idle mid-frame error", PAY'({rx_seq_error, rx_frame_valid}), 87'b10);
    // R7 stray beats while hunting
    beat(3'b010, 29'h5);
    check(rx_seq_error, "R7 stray beat 2", PAY'(rx_seq_error), 87'd1);
    beat(3'b100, 29'h6);
    check(rx_seq_error, "R7 stray beat 3", PAY'(rx_seq_error), 87'd1);
    // R8 resync on first beat in mid-frame
    beat(3'b001, 29'h0DDDDDDD);
    beat(3'b001, 29'h0EEEEEEE);
    check(rx_seq_error, "R8 early first beat error", PAY'(rx_seq_error), 87'd1);
    beat(3'b010, 29'h0FFFFFFF);
    check(!rx_seq_error, "R8 continues new frame", PAY'(rx_seq_error), 87'd0);
    beat(3'b100, 29'h01234567);
    check(rx_frame_valid && !rx_seq_error, "R8 resync frame strobe", PAY'({rx_frame_valid, rx_seq_error}), 87'b10);
    check(rx_payload == {29'h01234567, 29'h0FFFFFFF, 29'h0EEEEEEE}, "R8 resync payload",
          rx_payload, {29'h01234567, 29'h0FFFFFFF, 29'h0EEEEEEE});
    held = rx_payload;
    // R9 malformed tags
    beat(3'b011, 29'h7);
    check(rx_seq_error, "R9 tag 011", PAY'(rx_seq_error), 87'd1);
    beat(3'b111, 29'h8);
    check(rx_seq_error, "R9 tag 111", PAY'(rx_seq_error), 87'd1);
    beat(3'b110, 29'h9);
    check(rx_seq_error, "R9 tag 110", PAY'(rx_seq_error), 87'd1);
    // R10 idle while hunting
    for (int k = 0; k < 3; k++) begin
      beat(3'b000, 29'h1FFFFFFF);
      check(!rx_seq_error && !rx_frame_valid, "R10 idle while hunting", PAY'({rx_seq_error, rx_frame_valid}), 87'd0);
    end
    check(rx_payload == held, "R5 payload kept across errors", rx_payload, held);
    inj_word = '0;
    @(negedge clk);
    inj_en = 1'b0;

    send(pat(99), 1'b0);
    idle(8);
    check(rd == wr, "R4 all frames delivered", PAY'(rd), PAY'(wr));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule